// File: doc/BRIEF.md
# Retriggerable Overload Indicator

This block watches a stereo stream of signed 18-bit audio samples and raises a single overload flag whenever either channel comes close to digital full scale. A sample counts as close when its magnitude reaches 116818, which is about 1 dB below full swing. The positive full-scale limit is +131071 and the negative limit is -131072.

Once raised, the flag is held for a fixed number of sample periods, 512 by default. Each new close-to-full-scale sample restarts that hold period. A system controller can therefore poll the flag slowly and still see short peaks.

Samples arrive on a valid/ready stream. Both channels travel in the same beat. The block never applies back-pressure: `smp_ready` is tied high, and a beat is taken on every cycle where `smp_valid` is high. A standby input forces the flag low and clears the hold state. Beats that arrive during standby are ignored.

Top module: `ovl_indicator`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `ovl_flag` is 0 and the hold count is zero.
- R2: A positive sample qualifies when its value is at least 116818. So 116818 and 131071 qualify, and 116817 does not. Samples are 18-bit two's complement.
- R3: A negative sample qualifies when its magnitude is at least 116818. So -116818 and -131072 qualify, and -116817 and -1 do not.
- R4: A qualifying value on the left channel alone, or on the right channel alone, is enough to raise the flag.
- R5: `ovl_flag` rises on the clock edge that accepts a qualifying beat. It is low before that edge.
- R6: After the last qualifying beat, `ovl_flag` stays high through 511 further non-qualifying beats. It falls on the edge that accepts the 512th.
- R7: A qualifying beat while the flag is high restarts the full 512-beat hold. This includes a beat on the edge that would otherwise have expired the hold.
- R8: Cycles with `smp_valid` low neither reload nor decrement the hold count, whatever the sample values are.
- R9: While `standby` is high, `ovl_flag` is 0 in the same cycle and the hold count is cleared. Beats accepted during standby are ignored, so the flag stays low after standby ends until a new qualifying beat arrives.
- R10: `smp_ready` is 1 at all times, including during reset and standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | Standby state; forces the flag low and clears the hold |
| smp_valid | input | 1 | Stereo sample beat is present |
| smp_ready | output | 1 | Always high; the block takes every beat |
| smp_left | input | 18 | Left sample, two's complement |
| smp_right | input | 18 | Right sample, two's complement |
| ovl_flag | output | 1 | Overload indication |

## Verification
Two events can land on the same edge: a retrigger and the expiry of the hold. The bench lets 511 non-qualifying beats drain the count to one. It then presents a full-scale beat on the edge where the flag would otherwise fall. The flag must stay high, and must then last another 511 beats before falling on the 512th.

Standby meeting a qualifying beat is provoked the same way. The flag must read low in that cycle and stay low after standby is released.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;
  localparam int SAMPLE_W_DEF = 18;
  localparam int THRESH_DEF   = 116818;
  localparam int HOLD_DEF     = 512;
  localparam int NUM_CH       = 2;
endpackage

// File: rtl/ovl_near_fs.sv
`timescale 1ns/1ps
module ovl_near_fs #(
  parameter int W      = ovl_pkg::SAMPLE_W_DEF,
  parameter int THRESH = ovl_pkg::THRESH_DEF
) (
  input  logic [W-1:0] sample,
  output logic         hit
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] mag;

  always_comb begin
    if (sample[W-1]) mag = ~sample + 1'b1;
    else             mag = sample;
    hit = (mag >= W'(THRESH));
  end

  // Full-scale values on either side must always qualify.
  always_comb begin
    if (sample == MOST_NEG) assert_negfs_R3: assert (hit);
    if (sample == MOST_POS) assert_posfs_R2: assert (hit);
  end
endmodule

// File: rtl/ovl_hold_timer.sv
`timescale 1ns/1ps
module ovl_hold_timer #(
  parameter int HOLD = ovl_pkg::HOLD_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic standby,
  input  logic strobe,
  input  logic hit,
  output logic active
);
  localparam int CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD);

  logic [CNT_W-1:0] cnt;

  // Priority: standby clears, a qualifying beat reloads, other beats count down.
  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (standby)              cnt <= '0;
    else if (strobe && hit)        cnt <= HOLD_C;
    else if (strobe && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  assert_reset_R1: assert property (@(posedge clk) rst |=> (cnt == '0));
  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe && hit && !standby) |=> (cnt == HOLD_C));
  assert_countdown_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe && !hit && !standby && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !standby) |=> $stable(cnt));
  assert_standby_clear_R9: assert property (@(posedge clk) disable iff (rst)
    standby |=> (cnt == '0));
endmodule

// File: rtl/ovl_indicator.sv
`timescale 1ns/1ps
module ovl_indicator #(
  parameter int SAMPLE_W = ovl_pkg::SAMPLE_W_DEF,
  parameter int THRESH   = ovl_pkg::THRESH_DEF,
  parameter int HOLD     = ovl_pkg::HOLD_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                standby,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                ovl_flag
);
  localparam int NCH = ovl_pkg::NUM_CH;

  logic [SAMPLE_W-1:0] ch_sample [NCH];
  logic [NCH-1:0]      ch_hit;
  logic                any_hit;
  logic                hold_active;

  assign ch_sample[0] = smp_left;
  assign ch_sample[1] = smp_right;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ovl_near_fs #(.W(SAMPLE_W), .THRESH(THRESH)) u_cmp (
      .sample (ch_sample[c]),
      .hit    (ch_hit[c])
    );
  end

  assign any_hit = |ch_hit;

  ovl_hold_timer #(.HOLD(HOLD)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .standby (standby),
    .strobe  (smp_valid),
    .hit     (any_hit),
    .active  (hold_active)
  );

  assign smp_ready = 1'b1;
  assign ovl_flag  = hold_active && !standby;

  assert_prompt_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && any_hit && !standby) |=> (ovl_flag || standby));
  assert_ready_R10: assert property (@(posedge clk) smp_ready);
endmodule

// File: tb/ovl_indicator_tb.sv
`timescale 1ns/1ps
module ovl_indicator_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic standby = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [17:0] smp_left = '0;
  logic [17:0] smp_right = '0;
  logic ovl_flag;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ovl_indicator u_dut (
    .clk(clk), .rst(rst), .standby(standby), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
    .ovl_flag(ovl_flag)
  );

  localparam logic [17:0] FS  = 18'd131071;
  localparam logic [17:0] LOW = 18'd1000;

  // {left, right, expected flag}; negatives written as 2^18 + value
  localparam int NV = 11;
  localparam logic [36:0] VEC [NV] = '{
    {18'd0,      18'd0,      1'b0},
    {18'd116818, 18'd0,      1'b1},  // R2
    {18'd116817, 18'd0,      1'b0},  // R2
    {18'd131071, 18'd0,      1'b1},  // R2
    {18'd145326, 18'd0,      1'b1},  // R3 -116818
    {18'd145327, 18'd0,      1'b0},  // R3 -116817
    {18'd131072, 18'd0,      1'b1},  // R3 -131072
    {18'd0,      18'd131072, 1'b1},  // R4 right alone
    {18'd0,      18'd116817, 1'b0},  // R4
    {18'd262143, 18'd116818, 1'b1},  // R4 left -1, right hits
    {18'd116817, 18'd145327, 1'b0}   // R3 both just under
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [17:0] l, input logic [17:0] r,
                       input logic sb);
    smp_valid = v; smp_left = l; smp_right = r; standby = sb;
    @(negedge clk);
  endtask

  task automatic clear_hold();
    drive(1'b0, '0, '0, 1'b1);
    drive(1'b0, '0, '0, 1'b0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 flag in reset", ovl_flag, 1'b0);
    chk("R10 ready in reset", smp_ready, 1'b1);
    drive(1'b1, FS, FS, 1'b0);
    drive(1'b1, FS, FS, 1'b0);
    chk("R1 flag held in reset", ovl_flag, 1'b0);
    rst = 1'b0;
    drive(1'b0, '0, '0, 1'b0);
    chk("R1 flag after reset", ovl_flag, 1'b0);

    // Table walk: R2/R3/R4 qualification, R5 timing
    for (int i = 0; i < NV; i++) begin
      clear_hold();
      smp_valid = 1'b1; smp_left = VEC[i][36:19]; smp_right = VEC[i][18:1];
      #1;
      chk($sformatf("R5 pre-edge vector %0d", i), ovl_flag, 1'b0);
      @(negedge clk);
      chk($sformatf("R2/R3/R4 vector %0d", i), ovl_flag, VEC[i][0]);
      smp_valid = 1'b0;
    end

    // R6 hold length
    clear_hold();
    drive(1'b1, FS, '0, 1'b0);
    chk("R6 raised", ovl_flag, 1'b1);
    for (int i = 1; i <= 511; i++) begin
      drive(1'b1, LOW, LOW, 1'b0);
      chk($sformatf("R6 held beat %0d", i), ovl_flag, 1'b1);
    end
    drive(1'b1, LOW, LOW, 1'b0);
    chk("R6 falls on 512th beat", ovl_flag, 1'b0);

    // R7 retrigger on the expiry edge
    clear_hold();
    drive(1'b1, '0, FS, 1'b0);
    for (int i = 1; i <= 511; i++) drive(1'b1, LOW, LOW, 1'b0);
    chk("R7 high before retrigger", ovl_flag, 1'b1);
    drive(1'b1, 18'd131072, '0, 1'b0);
    chk("R7 retrigger at expiry", ovl_flag, 1'b1);
    for (int i = 1; i <= 511; i++) drive(1'b1, LOW, LOW, 1'b0);
    chk("R7 full hold after retrigger", ovl_flag, 1'b1);
    drive(1'b1, LOW, LOW, 1'b0);
    chk("R7 falls after restarted hold", ovl_flag, 1'b0);

    // R8 idle cycles neither reload nor count
    clear_hold();
    for (int i = 0; i < 5; i++) drive(1'b0, FS, FS, 1'b0);
    chk("R8 no valid no flag", ovl_flag, 1'b0);
    drive(1'b1, FS, '0, 1'b0);
    for (int i = 0; i < 300; i++) drive(1'b1, LOW, LOW, 1'b0);
    for (int i = 0; i < 20; i++) drive(1'b0, FS, FS, 1'b0);
    chk("R8 held across idle", ovl_flag, 1'b1);
    for (int i = 0; i < 211; i++) drive(1'b1, LOW, LOW, 1'b0);
    chk("R8 still high at 511th beat", ovl_flag, 1'b1);
    drive(1'b1, LOW, LOW, 1'b0);
    chk("R8 idle did not reload", ovl_flag, 1'b0);

    // R9 standby
    clear_hold();
    drive(1'b1, FS, FS, 1'b0);
    chk("R9 raised before standby", ovl_flag, 1'b1);
    standby = 1'b1; smp_valid = 1'b0;
    #1;
    chk("R9 low same cycle", ovl_flag, 1'b0);
    chk("R10 ready in standby", smp_ready, 1'b1);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, FS, FS, 1'b1);
      chk("R9 beats in standby ignored", ovl_flag, 1'b0);
    end
    drive(1'b0, '0, '0, 1'b0);
    chk("R9 low after release", ovl_flag, 1'b0);
    drive(1'b1, LOW, LOW, 1'b0);
    chk("R9 hold was cleared", ovl_flag, 1'b0);
    drive(1'b1, '0, 18'd145326, 1'b0);
    chk("R9 new hit after standby", ovl_flag, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule